// File: doc/BRIEF.md
# Wavefront Sub-Block Mode-Search Scheduler

This block drives the intra-prediction mode search of one 16x16 macroblock, split into a 4x4 grid of 4x4-pixel sub-blocks. It walks the grid in diagonal wavefront steps. Step `s` contains every sub-block at row `r`, column `c` with `c + 2*r == s`, so a macroblock takes ten steps. Every sub-block in a step depends only on sub-blocks from earlier steps. Because of this, two sub-blocks that share a step can be interleaved in one pipelined issue stream.

On each cycle that it is issuing and not stalled, the block presents one (row, column, mode) triple to a downstream evaluation pipeline, which consumes one triple per cycle. After the last triple of a step, the block stops issuing. It waits for the pipeline to report that the step has finished, since reconstruction of that step feeds the next one. After the handshake for the final step, it raises a one-cycle completion pulse and returns to idle.

The grid size and the candidate mode count are parameters. The defaults are a 4x4 grid and 10 modes.

Top module: `wf_mode_sched`

## Requirements
- R1: After reset `valid_o` and `mb_done_o` are low and the block stays idle. A `start_i` sampled high while idle makes `valid_o` high on the next cycle, carrying the first triple of step 0.
- R2: Steps run in order 0 to 9. Step s issues only sub-blocks with `col_o + 2*row_o == s`, where `row_o` and `col_o` are 2-bit binary indices. Over one macroblock, every one of the 16 sub-blocks is issued with all 10 modes exactly once.
- R3: Steps 2 to 7 hold two sub-blocks and issue 20 triples. Even iterations (0, 2, 4, ...) go to the sub-block with the smaller row and odd iterations go to the one with the larger row. Steps 0, 1, 8 and 9 hold one sub-block and issue 10 triples.
- R4: `mode_o` is a 4-bit binary value equal to the iteration index divided by the number of sub-blocks in the step, so each sub-block sees modes 0 to 9 in ascending order. With `stall_i` low, one triple is issued per cycle.
- R5: While `stall_i` is high during issue, `valid_o`, `row_o`, `col_o` and `mode_o` hold their values and no iteration is consumed.
- R6: After the last triple of a step, `valid_o` stays low until `step_done_i` is sampled high. The next step then starts on the following cycle. `step_done_i` has no effect while triples are still being issued.
- R7: The `step_done_i` handshake for step 9 makes `mb_done_o` high for exactly one cycle, with `valid_o` low. The block is then idle.
- R8: `start_i` has no effect while a macroblock is in progress. `step_done_i` has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a macroblock (sampled while idle) |
| stall_i | input | 1 | Downstream back-pressure; freezes issue |
| step_done_i | input | 1 | Evaluation of the current step has finished |
| valid_o | output | 1 | Triple on row/col/mode is valid |
| row_o | output | 2 | Sub-block row index |
| col_o | output | 2 | Sub-block column index |
| mode_o | output | 4 | Candidate mode index |
| mb_done_o | output | 1 | One-cycle pulse when the macroblock completes |

## Verification
The assertions take for granted three things about the environment. First, `stall_i` may be raised on any cycle of issue and the triple is simply held. Second, `step_done_i` counts only while the block is waiting at a step boundary. Third, `start_i` counts only while the block is idle. The stimulus keeps to these rules while still probing them. It stalls on two of every three cycles in one run. It holds `start_i` and `step_done_i` high throughout issue in another run, and drives `start_i` during the boundary waits. It pulses `step_done_i` while idle. In every case the expected triple stream is rebuilt from the step formula alone, so a stray handshake shows up as a skipped or repeated triple.

// File: rtl/wf_sched_pkg.sv
`timescale 1ns/1ps
package wf_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } sched_state_e;
endpackage

// File: rtl/wf_step_planner.sv
`timescale 1ns/1ps
// Finds the lowest row and the number of sub-blocks on one wavefront step.
module wf_step_planner #(
  parameter int GRID   = 4,
  parameter int STEP_W = 4,
  parameter int ROW_W  = 2,
  parameter int CNT_W  = 2
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [ROW_W-1:0]  row_lo_o,
  output logic [CNT_W-1:0]  cnt_o
);
  always_comb begin
    int  c_v;
    logic found_v;
    row_lo_o = '0;
    cnt_o    = '0;
    found_v  = 1'b0;
    for (int r = 0; r < GRID; r++) begin
      c_v = int'(step_i) - 2 * r;
      if (c_v >= 0 && c_v < GRID) begin
        if (!found_v) begin
          row_lo_o = ROW_W'(r);
          found_v  = 1'b1;
        end
        cnt_o = cnt_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wf_iter_counter.sv
`timescale 1ns/1ps
// Slot-major interleave: slot cycles fastest, mode advances when slots wrap.
module wf_iter_counter #(
  parameter int N_MODES = 10,
  parameter int SLOT_W  = 1,
  parameter int MODE_W  = 4,
  parameter int CNT_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [MODE_W-1:0] mode_q;
  logic              slot_wrap;

  assign slot_wrap = (CNT_W'(slot_q) + CNT_W'(1)) == cnt_i;
  assign last_o    = slot_wrap && (mode_q == MODE_W'(N_MODES - 1));
  assign slot_o    = slot_q;
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      mode_q <= '0;
    end else if (clear_i) begin
      slot_q <= '0;
      mode_q <= '0;
    end else if (adv_i) begin
      if (slot_wrap) begin
        slot_q <= '0;
        mode_q <= mode_q + MODE_W'(1);
      end else begin
        slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wf_mode_sched.sv
`timescale 1ns/1ps
module wf_mode_sched
  import wf_sched_pkg::*;
#(
  parameter int GRID    = 4,
  parameter int N_MODES = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       stall_i,
  input  logic                       step_done_i,
  output logic                       valid_o,
  output logic [$clog2(GRID)-1:0]    row_o,
  output logic [$clog2(GRID)-1:0]    col_o,
  output logic [$clog2(N_MODES)-1:0] mode_o,
  output logic                       mb_done_o
);
  localparam int ROW_W        = $clog2(GRID);
  localparam int MODE_W       = $clog2(N_MODES);
  localparam int NUM_STEPS    = 3 * (GRID - 1) + 1;
  localparam int STEP_W       = $clog2(NUM_STEPS);
  localparam int MAX_PER_STEP = (GRID + 1) / 2;
  localparam int SLOT_W       = (MAX_PER_STEP > 1) ? $clog2(MAX_PER_STEP) : 1;
  localparam int CNT_W        = $clog2(MAX_PER_STEP + 1);

  sched_state_e      state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              mb_done_q, mb_done_d;

  logic [ROW_W-1:0]  row_lo;
  logic [CNT_W-1:0]  blk_cnt;
  logic [SLOT_W-1:0] slot;
  logic [MODE_W-1:0] mode;
  logic              iter_last;
  logic              cnt_clear, cnt_adv;
  logic              last_step;

  wf_step_planner #(
    .GRID(GRID), .STEP_W(STEP_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_planner (
    .step_i  (step_q),
    .row_lo_o(row_lo),
    .cnt_o   (blk_cnt)
  );

  wf_iter_counter #(
    .N_MODES(N_MODES), .SLOT_W(SLOT_W), .MODE_W(MODE_W), .CNT_W(CNT_W)
  ) u_iter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(cnt_clear),
    .adv_i  (cnt_adv),
    .cnt_i  (blk_cnt),
    .slot_o (slot),
    .mode_o (mode),
    .last_o (iter_last)
  );

  assign last_step = (step_q == STEP_W'(NUM_STEPS - 1));
  assign cnt_adv   = (state_q == ST_ISSUE) && !stall_i;

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    mb_done_d = 1'b0;
    cnt_clear = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_ISSUE;
        step_d    = '0;
        cnt_clear = 1'b1;
      end
      ST_ISSUE: if (cnt_adv && iter_last) begin
        state_d = ST_WAIT;
      end
      ST_WAIT: if (step_done_i) begin
        cnt_clear = 1'b1;
        if (last_step) begin
          state_d   = ST_IDLE;
          mb_done_d = 1'b1;
        end else begin
          state_d = ST_ISSUE;
          step_d  = step_q + STEP_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      mb_done_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      step_q    <= step_d;
      mb_done_q <= mb_done_d;
    end
  end

  // Even slots map to the lower row; the column follows from the step index.
  assign valid_o   = (state_q == ST_ISSUE);
  assign row_o     = row_lo + ROW_W'(slot);
  assign col_o     = ROW_W'(int'(step_q) - 2 * int'(row_o));
  assign mode_o    = mode;
  assign mb_done_o = mb_done_q;

  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (valid_o && mode_o == '0));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stall_i) |=> (valid_o && $stable(row_o) && $stable(col_o) && $stable(mode_o)));

  p_mode_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !stall_i) |=>
      (!valid_o || mode_o == $past(mode_o) || 32'(mode_o) == 32'($past(mode_o)) + 1));

  p_mode_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (32'(mode_o) < N_MODES));

  p_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !step_done_i && state_q == ST_WAIT) |=> !valid_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_done_o |=> !mb_done_o);

  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_done_o |-> !valid_o);
endmodule

// File: tb/wf_mode_sched_tb.sv
`timescale 1ns/1ps
module wf_mode_sched_tb;
  localparam int GRID    = 4;
  localparam int N_MODES = 10;
  localparam int NSTEPS  = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, stall_i = 1'b0, step_done_i = 1'b0;
  logic       valid_o, mb_done_o;
  logic [1:0] row_o, col_o;
  logic [3:0] mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;
  int seen [GRID][GRID];

  always #2.5 clk = ~clk;

  wf_mode_sched #(.GRID(GRID), .N_MODES(N_MODES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .stall_i(stall_i),
    .step_done_i(step_done_i), .valid_o(valid_o), .row_o(row_o),
    .col_o(col_o), .mode_o(mode_o), .mb_done_o(mb_done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One macroblock; stall_pat>0 stalls on cycles where cyc%stall_pat != 0.
  task automatic run_mb(input int stall_pat, input int wait_cyc, input bit poke);
    int cyc = 0;
    for (int r = 0; r < GRID; r++)
      for (int c = 0; c < GRID; c++) seen[r][c] = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int s = 0; s < NSTEPS; s++) begin
      int rows[4];
      int cnt = 0;
      int total;
      int i = 0;
      for (int r = 0; r < GRID; r++)
        if (s - 2*r >= 0 && s - 2*r < GRID) begin rows[cnt] = r; cnt++; end
      total = cnt * N_MODES;
      chk(total == ((s >= 2 && s <= 7) ? 20 : 10), "R3", "step length", total, 0);
      while (i < total) begin
        int er = rows[i % cnt];
        int ec = s - 2*er;
        int em = i / cnt;
        bit st;
        chk(valid_o == 1'b1, "R4", "valid during issue", int'(valid_o), 1);
        chk(row_o == er[1:0] && col_o == ec[1:0], "R3",
            "row*16+col", int'(row_o)*16 + int'(col_o), er*16 + ec);
        chk(int'(col_o) + 2*int'(row_o) == s, "R2", "wavefront step",
            int'(col_o) + 2*int'(row_o), s);
        chk(mode_o == em[3:0], "R4", "mode", int'(mode_o), em);
        chk(mb_done_o == 1'b0, "R7", "done during issue", int'(mb_done_o), 0);
        st = (stall_pat > 0) && ((cyc % stall_pat) != 0);
        cyc++;
        stall_i     = st;
        start_i     = poke;
        step_done_i = poke;
        if (!st) begin
          i++;
          seen[er][ec]++;
        end
        @(negedge clk);
      end
      stall_i = 1'b0; start_i = 1'b0; step_done_i = 1'b0;
      for (int w = 0; w < wait_cyc; w++) begin
        chk(valid_o == 1'b0, "R6", "valid while waiting", int'(valid_o), 0);
        start_i = poke;
        @(negedge clk);
      end
      start_i = 1'b0;
      chk(valid_o == 1'b0, "R6", "valid at boundary", int'(valid_o), 0);
      step_done_i = 1'b1;
      @(negedge clk);
      step_done_i = 1'b0;
    end
    chk(mb_done_o == 1'b1, "R7", "done pulse", int'(mb_done_o), 1);
    chk(valid_o == 1'b0, "R7", "valid at done", int'(valid_o), 0);
    @(negedge clk);
    chk(mb_done_o == 1'b0, "R7", "done width", int'(mb_done_o), 0);
    chk(valid_o == 1'b0, "R7", "idle after done", int'(valid_o), 0);
    for (int r = 0; r < GRID; r++)
      for (int c = 0; c < GRID; c++)
        chk(seen[r][c] == N_MODES, "R2", "issues per sub-block", seen[r][c], N_MODES);
  endtask

  task automatic t_reset();
    chk(valid_o == 1'b0, "R1", "valid in reset", int'(valid_o), 0);
    chk(mb_done_o == 1'b0, "R1", "done in reset", int'(mb_done_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1", "idle without start", int'(valid_o), 0);
  endtask

  task automatic t_plain();  run_mb(0, 0, 1'b0); endtask
  task automatic t_stall();  run_mb(3, 2, 1'b0); endtask
  task automatic t_poke();   run_mb(0, 3, 1'b1); endtask

  task automatic t_idle_ignore();
    @(negedge clk); step_done_i = 1'b1; stall_i = 1'b1;
    @(negedge clk); step_done_i = 1'b0; stall_i = 1'b0;
    chk(valid_o == 1'b0, "R8", "step_done while idle", int'(valid_o), 0);
    chk(mb_done_o == 1'b0, "R8", "done while idle", int'(mb_done_o), 0);
    @(negedge clk);
    chk(valid_o == 1'b0, "R8", "still idle", int'(valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_plain();
    t_idle_ignore();
    t_stall();
    t_poke();
    t_plain();
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule